// File: doc/BRIEF.md
# Write Leveling Delay Trainer

This block trains the outgoing data strobe of each byte lane so that its edge lines up with the memory clock as the memory device sees it. A start pulse makes the engine issue a mode-register write that puts the memory into leveling mode. The engine then works through the lanes one at a time. For each lane it drives a strobe pulse at the current delay tap and waits a programmable response latency. It then samples the one-bit answer the memory returns on that lane's data lines, which is the clock level the memory captured on the strobe edge. After the sample it waits a fixed gap and moves the tap up by one.

A lane is trained when the answer goes from 0 on one step to 1 on the next. The tap that produced the 1 is stored as the aligned value. A 1 with no 0 sampled before it on the same lane is not taken as the edge. If the last tap is sampled without finding an edge, the lane is marked failed. Once the last lane has finished, a second mode-register write takes the memory out of leveling mode. Done then rises, and the per-lane pass vector and the stored taps stay readable until the next start. The delay line itself sits outside this block and is steered through the tap and lane select outputs.

Top module: `wl_trainer`

## Requirements
- R1: While reset is held and after it is released, before any start, busy, done, strobe_pulse and mrw_valid are 0, and every bit of lane_pass and lane_taps is 0.
- R2: A start pulse accepted while idle or done produces exactly one cycle with mrw_valid=1 and mrw_enter=1. This is the cycle before the first strobe pulse of the run, and no strobe pulse comes before it.
- R3: strobe_pulse is high for a single cycle. The feedback bit of the lane being trained is sampled at the clock edge that ends the cycle lying resp_lat+1 cycles after the strobe cycle. Feedback at any other edge has no effect.
- R4: After each sample, a fixed wait of GAP_CYC+1 cycles passes before the next strobe. As a result, consecutive strobe pulses on one lane start exactly resp_lat+GAP_CYC+3 cycles apart.
- R5: Each lane's first strobe uses tap 0. Each following strobe on the same lane uses the previous tap plus one, up to tap 2^TAP_W-1 (63 by default).
- R6: When a lane samples 1 directly after sampling 0, training of that lane stops. Its lane_pass bit becomes 1, and its field lane_taps[l*TAP_W +: TAP_W] holds the tap of the strobe that returned the 1.
- R7: Ones sampled before the first 0 of a lane are not an edge. Stepping continues until a 0 followed by a 1 is seen, and the stored tap is the one of that later 1.
- R8: If the tap 2^TAP_W-1 is sampled without completing a 0-to-1 edge, the lane's pass bit is 0 and its tap field is 0. Training then moves on to the next lane.
- R9: Lanes are trained in order 0, 1, ..., N_LANES-1, each with its own feedback bit fb[l] and its own result. lane_sel changes only to the next lane or back to 0.
- R10: After the last lane, exactly one cycle with mrw_valid=1 and mrw_enter=0 follows. No strobe comes after it. Then done rises with busy 0, and done, lane_pass and lane_taps hold until the next start.
- R11: A start pulse while busy is ignored. No new entry write is issued, and the run in progress continues to the same results.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Start pulse, taken when idle or done |
| resp_lat | input | LAT_W | Cycles to wait after a strobe before sampling feedback |
| fb | input | N_LANES | Sampled-clock feedback bit per lane |
| mrw_valid | output | 1 | Mode-register write request, one cycle |
| mrw_enter | output | 1 | With mrw_valid: 1 enters leveling mode, 0 leaves it |
| strobe_pulse | output | 1 | Drive one strobe pulse on the selected lane |
| lane_sel | output | LANE_W | Lane currently being trained |
| tap_sel | output | TAP_W | Delay tap applied to the selected lane's strobe |
| busy | output | 1 | A training run is in progress |
| done | output | 1 | Run finished, results valid |
| lane_pass | output | N_LANES | Per-lane pass flag |
| lane_taps | output | N_LANES*TAP_W | Per-lane aligned tap, lane l at [l*TAP_W +: TAP_W] |

## Verification
The edge-tracking flag, the tap counter and the latency counter each show a fault at the ports soon after it happens. A wrong flag or a wrong sampling instant shows up as a wrong pass bit or tap for that lane as soon as done rises. This holds because the bench drives the correct feedback only at the sampling edge and the inverse at every other edge. A slip in the tap or lane counter is visible at the very next strobe, as a tap that did not step by one or a lane out of order. A wrong wait length shows up in the spacing of the next strobe pulse.

// File: rtl/wl_pkg.sv
package wl_pkg;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_ENTER = 3'd1,
    ST_PULSE = 3'd2,
    ST_WAIT  = 3'd3,
    ST_GAP   = 3'd4,
    ST_EXIT  = 3'd5,
    ST_DONE  = 3'd6
  } wl_state_e;

endpackage

// File: rtl/wl_countdown.sv
// Loadable down counter; stops at zero.
module wl_countdown #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         is_zero
);

  logic [W-1:0] cnt_q;
  logic         cnt_en;
  logic [W-1:0] cnt_d;

  always_comb begin
    cnt_en = load || (cnt_q != '0);
    cnt_d  = load ? load_val : cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign is_zero = (cnt_q == '0);

endmodule

// File: rtl/wl_lane_bank.sv
// Per-lane result registers: pass flag and aligned tap.
module wl_lane_bank #(
  parameter int N_LANES = 4,
  parameter int TAP_W   = 6,
  parameter int LANE_W  = 2
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     clear,
  input  logic                     wr_en,
  input  logic [LANE_W-1:0]        wr_lane,
  input  logic                     wr_pass,
  input  logic [TAP_W-1:0]         wr_tap,
  output logic [N_LANES-1:0]       pass_vec,
  output logic [N_LANES*TAP_W-1:0] tap_vec
);

  for (genvar g = 0; g < N_LANES; g++) begin : g_lane
    logic             hit;
    logic             pass_q;
    logic [TAP_W-1:0] tap_q;

    assign hit = wr_en && (wr_lane == LANE_W'(g));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        pass_q <= 1'b0;
        tap_q  <= '0;
      end else if (clear) begin
        pass_q <= 1'b0;
        tap_q  <= '0;
      end else if (hit) begin
        pass_q <= wr_pass;
        tap_q  <= wr_pass ? wr_tap : '0;
      end
    end

    assign pass_vec[g]                 = pass_q;
    assign tap_vec[g*TAP_W +: TAP_W]   = tap_q;

    // R6: a pass needs a 0 sample before the 1, so its tap is never 0
    a_r6_pass_tap_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
      pass_q |-> (tap_q != '0));
  end

endmodule

// File: rtl/wl_trainer.sv
module wl_trainer
  import wl_pkg::*;
#(
  parameter int N_LANES = 4,
  parameter int TAP_W   = 6,
  parameter int LAT_W   = 4,
  parameter int GAP_CYC = 2,
  localparam int LANE_W = (N_LANES > 1) ? $clog2(N_LANES) : 1
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     start,
  input  logic [LAT_W-1:0]         resp_lat,
  input  logic [N_LANES-1:0]       fb,
  output logic                     mrw_valid,
  output logic                     mrw_enter,
  output logic                     strobe_pulse,
  output logic [LANE_W-1:0]        lane_sel,
  output logic [TAP_W-1:0]         tap_sel,
  output logic                     busy,
  output logic                     done,
  output logic [N_LANES-1:0]       lane_pass,
  output logic [N_LANES*TAP_W-1:0] lane_taps
);

  localparam int GAP_W                = (GAP_CYC > 0) ? $clog2(GAP_CYC + 1) : 1;
  localparam logic [TAP_W-1:0]  TAP_MAX   = {TAP_W{1'b1}};
  localparam logic [LANE_W-1:0] LANE_LAST = LANE_W'(N_LANES - 1);

  wl_state_e         state_q, state_d;
  logic [LANE_W-1:0] lane_q, lane_d;
  logic [TAP_W-1:0]  tap_q, tap_d;
  logic              zero_seen_q, zero_seen_d;

  logic lat_zero, gap_zero;
  logic launch, sample, fb_bit, edge_hit, lane_end, pos_en;

  // ---- decode of the current step
  always_comb begin
    launch   = start && ((state_q == ST_IDLE) || (state_q == ST_DONE));
    sample   = (state_q == ST_WAIT) && lat_zero;
    fb_bit   = fb[lane_q];
    edge_hit = sample && fb_bit && zero_seen_q;
    lane_end = edge_hit || (sample && (tap_q == TAP_MAX));
    pos_en   = launch || sample;
  end

  // ---- next state
  always_comb begin
    state_d     = state_q;
    lane_d      = lane_q;
    tap_d       = tap_q;
    zero_seen_d = zero_seen_q;
    unique case (state_q)
      ST_IDLE, ST_DONE: begin
        if (start) begin
          state_d     = ST_ENTER;
          lane_d      = '0;
          tap_d       = '0;
          zero_seen_d = 1'b0;
        end
      end
      ST_ENTER: state_d = ST_PULSE;
      ST_PULSE: state_d = ST_WAIT;
      ST_WAIT: begin
        if (sample) begin
          if (lane_end) begin
            if (lane_q == LANE_LAST) begin
              state_d = ST_EXIT;
            end else begin
              state_d     = ST_GAP;
              lane_d      = lane_q + 1'b1;
              tap_d       = '0;
              zero_seen_d = 1'b0;
            end
          end else begin
            state_d     = ST_GAP;
            tap_d       = tap_q + 1'b1;
            zero_seen_d = ~fb_bit;
          end
        end
      end
      ST_GAP:  if (gap_zero) state_d = ST_PULSE;
      ST_EXIT: state_d = ST_DONE;
      default: state_d = ST_IDLE;
    endcase
  end

  // ---- registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
    end else begin
      state_q <= state_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lane_q      <= '0;
      tap_q       <= '0;
      zero_seen_q <= 1'b0;
    end else if (pos_en) begin
      lane_q      <= lane_d;
      tap_q       <= tap_d;
      zero_seen_q <= zero_seen_d;
    end
  end

  // ---- response latency and post-sample gap
  wl_countdown #(.W(LAT_W)) u_lat (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (state_q == ST_PULSE),
    .load_val (resp_lat),
    .is_zero  (lat_zero)
  );

  wl_countdown #(.W(GAP_W)) u_gap (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (sample),
    .load_val (GAP_W'(GAP_CYC)),
    .is_zero  (gap_zero)
  );

  // ---- results
  wl_lane_bank #(.N_LANES(N_LANES), .TAP_W(TAP_W), .LANE_W(LANE_W)) u_bank (
    .clk      (clk),
    .rst_n    (rst_n),
    .clear    (launch),
    .wr_en    (lane_end),
    .wr_lane  (lane_q),
    .wr_pass  (edge_hit),
    .wr_tap   (tap_q),
    .pass_vec (lane_pass),
    .tap_vec  (lane_taps)
  );

  // ---- outputs
  assign mrw_valid    = (state_q == ST_ENTER) || (state_q == ST_EXIT);
  assign mrw_enter    = (state_q == ST_ENTER);
  assign strobe_pulse = (state_q == ST_PULSE);
  assign lane_sel     = lane_q;
  assign tap_sel      = tap_q;
  assign busy         = (state_q != ST_IDLE) && (state_q != ST_DONE);
  assign done         = (state_q == ST_DONE);

  // ---- assertions
  a_r3_strobe_single: assert property (@(posedge clk) disable iff (!rst_n)
    strobe_pulse |=> !strobe_pulse);

  a_r2_mrw_apart_from_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    !(mrw_valid && strobe_pulse));

  a_r2_run_opens_with_entry: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> (mrw_valid && mrw_enter));

  a_r5_tap_steps: assert property (@(posedge clk) disable iff (!rst_n)
    (tap_sel != $past(tap_sel)) |-> ((tap_sel == $past(tap_sel) + 1'b1) || (tap_sel == '0)));

  a_r9_lane_order: assert property (@(posedge clk) disable iff (!rst_n)
    (lane_sel != $past(lane_sel)) |-> ((lane_sel == $past(lane_sel) + 1'b1) || (lane_sel == '0)));

  a_r10_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  a_r11_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start) |=> !(mrw_valid && mrw_enter));

endmodule

// File: tb/wl_trainer_test.sv
module wl_trainer_test;
  localparam int NL   = 4;
  localparam int TW   = 6;
  localparam int LW   = 4;
  localparam int GAPC = 2;
  localparam int NT   = 64;
  localparam int SW   = 2;

  logic             clk = 1'b0;
  logic             rst_n;
  logic             start;
  logic [LW-1:0]    resp_lat;
  logic [NL-1:0]    fb;
  logic             mrw_valid, mrw_enter, strobe_pulse, busy, done;
  logic [SW-1:0]    lane_sel;
  logic [TW-1:0]    tap_sel;
  logic [NL-1:0]    lane_pass;
  logic [NL*TW-1:0] lane_taps;

  wl_trainer #(.N_LANES(NL), .TAP_W(TW), .LAT_W(LW), .GAP_CYC(GAPC)) uut (
    .clk(clk), .rst_n(rst_n), .start(start), .resp_lat(resp_lat), .fb(fb),
    .mrw_valid(mrw_valid), .mrw_enter(mrw_enter), .strobe_pulse(strobe_pulse),
    .lane_sel(lane_sel), .tap_sel(tap_sel), .busy(busy), .done(done),
    .lane_pass(lane_pass), .lane_taps(lane_taps)
  );

  always #10 clk = ~clk;

  int n_checks = 0;
  int n_fail   = 0;

  task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  logic [NT-1:0] pat [NL];
  int lat_cfg = 0;
  int run_id  = 0;

  // monitor and feedback model
  int seen_run = -1;
  int enter_cnt = 0, exit_cnt = 0, strobe_cnt = 0, late_strobes = 0;
  int cyc = 0, last_strobe_cyc = 0, prev_lane = 0, prev_tap = 0;
  bit prev_strobe = 1'b0, armed = 1'b0;
  int n_since = 0, cur_lane = 0, cur_tap = 0;

  always @(negedge clk) begin
    cyc++;
    if (seen_run != run_id) begin
      seen_run = run_id; enter_cnt = 0; exit_cnt = 0; strobe_cnt = 0;
      late_strobes = 0; armed = 1'b0;
    end
    if (rst_n === 1'b1) begin
      if (mrw_valid) begin
        if (mrw_enter) begin
          enter_cnt++;
          check(strobe_cnt == 0, "R2", "entry write before first strobe", strobe_cnt, 0);
        end else exit_cnt++;
      end
      if (strobe_pulse) begin
        check(!prev_strobe, "R3", "strobe lasts one cycle", int'(prev_strobe), 0);
        if (exit_cnt != 0) late_strobes++;
        if (strobe_cnt == 0) begin
          check(lane_sel == 0, "R9", "first lane", int'(lane_sel), 0);
          check(tap_sel == 0, "R5", "first tap", int'(tap_sel), 0);
        end else if (int'(lane_sel) == prev_lane) begin
          check(int'(tap_sel) == prev_tap + 1, "R5", "tap step", int'(tap_sel), prev_tap + 1);
          check(cyc - last_strobe_cyc == lat_cfg + GAPC + 3, "R4", "strobe spacing",
                cyc - last_strobe_cyc, lat_cfg + GAPC + 3);
        end else begin
          check(int'(lane_sel) == prev_lane + 1, "R9", "lane order", int'(lane_sel), prev_lane + 1);
          check(tap_sel == 0, "R5", "tap restarts on new lane", int'(tap_sel), 0);
        end
        prev_lane = int'(lane_sel); prev_tap = int'(tap_sel);
        last_strobe_cyc = cyc; strobe_cnt++;
        armed = 1'b1; n_since = 0; cur_lane = int'(lane_sel); cur_tap = int'(tap_sel);
      end else if (armed) n_since++;
    end
    prev_strobe = strobe_pulse;
    // R3: the true answer is present only around the sampling edge; inverse elsewhere
    for (int l = 0; l < NL; l++) begin
      logic b;
      b = pat[cur_lane][cur_tap];
      fb[l] = (armed && n_since == lat_cfg + 1 && l == cur_lane) ? b : ~b;
    end
  end

  function automatic logic [NT-1:0] make_pat(input int kind, input int a, input int e);
    logic [NT-1:0] p;
    for (int t = 0; t < NT; t++) begin
      case (kind)
        0: p[t] = (t >= e);
        1: p[t] = (t < a) || (t >= e);
        2: p[t] = 1'b0;
        3: p[t] = 1'b1;
        default: p[t] = 1'b0;
      endcase
    end
    if (kind == 4) p = {$urandom, $urandom};
    return p;
  endfunction

  function automatic void ref_lane(input logic [NT-1:0] p, output bit ps, output int tp);
    bit z;
    z = 1'b0; ps = 1'b0; tp = 0;
    for (int t = 0; t < NT; t++) begin
      if (p[t] && z) begin ps = 1'b1; tp = t; return; end
      z = !p[t];
    end
  endfunction

  function automatic string kind_req(input int kind);
    case (kind)
      0: return "R6";
      1: return "R7";
      2, 3: return "R8";
      default: return "R9";
    endcase
  endfunction

  task automatic run(input int k[NL], input int a[NL], input int e[NL], input int lat, input bit poke);
    int w;
    logic [NL-1:0]    pass_snap;
    logic [NL*TW-1:0] tap_snap;
    for (int l = 0; l < NL; l++) pat[l] = make_pat(k[l], a[l], e[l]);
    lat_cfg  = lat;
    resp_lat = LW'(lat);
    run_id++;
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    w = 0;
    while (!done && w < 60000) begin
      if (poke && w == 150) begin
        check(busy, "R11", "busy when extra start is given", int'(busy), 1);
        start = 1'b1; @(negedge clk); start = 1'b0; w++;
      end
      @(negedge clk); w++;
    end
    if (!done) begin
      check(1'b0, "R10", "done never rose", 0, 1);
      return;
    end
    check(!busy, "R10", "busy low with done", int'(busy), 0);
    check(enter_cnt == 1, poke ? "R11" : "R2", "entry write count", enter_cnt, 1);
    check(exit_cnt == 1, "R10", "exit write count", exit_cnt, 1);
    check(late_strobes == 0, "R10", "strobes after exit write", late_strobes, 0);
    for (int l = 0; l < NL; l++) begin
      bit ps; int tp;
      ref_lane(pat[l], ps, tp);
      check(lane_pass[l] == ps, kind_req(k[l]), $sformatf("lane %0d pass", l), int'(lane_pass[l]), int'(ps));
      check(int'(lane_taps[l*TW +: TW]) == tp, kind_req(k[l]), $sformatf("lane %0d tap", l),
            int'(lane_taps[l*TW +: TW]), tp);
    end
    pass_snap = lane_pass; tap_snap = lane_taps;
    repeat (5) @(negedge clk);
    check(done, "R10", "done holds", int'(done), 1);
    check(lane_pass == pass_snap && lane_taps == tap_snap, "R10", "results hold", 0, 0);
  endtask

  initial begin
    int k[NL], a[NL], e[NL];
    void'($urandom(1234));
    for (int l = 0; l < NL; l++) pat[l] = '0;
    rst_n = 1'b0; start = 1'b0; resp_lat = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    // R1 reset state
    check(!busy && !done, "R1", "busy/done after reset", int'({busy, done}), 0);
    check(!strobe_pulse && !mrw_valid, "R1", "strobe/mrw after reset", int'({strobe_pulse, mrw_valid}), 0);
    check(lane_pass == 0 && lane_taps == 0, "R1", "results after reset", int'(lane_pass), 0);

    // directed: earliest edge, leading ones, never one, always one; zero latency
    k = '{0, 1, 2, 3}; a = '{0, 3, 0, 0}; e = '{1, 10, 0, 0};
    run(k, a, e, 0, 1'b0);
    // directed: edge on last tap, noise, leading one then immediate edge; start poked while busy
    k = '{0, 4, 1, 0}; a = '{0, 0, 1, 0}; e = '{63, 0, 2, 40};
    run(k, a, e, 5, 1'b1);
    // random runs
    for (int r = 0; r < 8; r++) begin
      for (int l = 0; l < NL; l++) begin
        k[l] = int'($urandom_range(0, 4));
        e[l] = int'($urandom_range(2, 63));
        a[l] = int'($urandom_range(1, e[l] - 1));
      end
      run(k, a, e, int'($urandom_range(0, 7)), 1'b0);
    end
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    n_checks++; n_fail++;
    $display("FAIL watchdog: actual %0d expected %0d", 190000, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

endmodule